// File: doc/BRIEF.md
# SPI Status Flag Controller with Debug-Break Protection

This block holds the status side of a serial peripheral: the transmit-empty, receive-full and overflow flags, the received byte seen by the CPU, and the two interrupt requests. It sits between a CPU register port and a byte shifter. The CPU port gives one-cycle strobes for a status read, a data read and a data write. The shifter port is a start strobe with the outgoing byte, and a done pulse with the byte that came in. Serial clocking and pin handling are left to the shifter.

Receive-full and overflow are cleared in two steps: first a status read while the flag is set, then a data read. The first step is remembered, so the second step can come later. While a debug break is active and the break-clear-enable input is low, CPU accesses cannot change any flag and cannot start a transfer. A first step taken before the break still counts after the break ends. With break-clear-enable high, clearing works normally during the break. The stop-mode input freezes the whole block. A reset asserted during stop aborts any transfer and returns the block to its reset state.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, ovf is 0, sh_start is 0 and rx_data is all zeros.
- R2: A sh_done pulse while rx_full is 0 (or while rx_full is being cleared in the same cycle) sets rx_full and copies sh_rx_byte into rx_data on that clock edge.
- R3: A sh_done pulse while rx_full is 1 and not being cleared in that cycle sets ovf and leaves rx_data unchanged.
- R4: rx_full clears on a data_rd cycle if a status read saw rx_full at 1 since the last clear. A data_rd that was not preceded by such a status read leaves rx_full set.
- R5: ovf is cleared by the same two-step sequence, using its own remembered first step.
- R6: A permitted data_wr while the shifter is idle (or being freed by sh_done in the same cycle) drives sh_start high for exactly one cycle after the edge, with sh_tx_byte set to the written byte, and tx_empty stays 1. A permitted data_wr while the shifter is busy stores the byte and clears tx_empty. The next sh_done then starts that stored byte and sets tx_empty again. A later write while tx_empty is 0 replaces the stored byte.
- R7: While brk_active is 1 and brk_clr_en is 0, stat_rd, data_rd and data_wr change no flag, record no first step, and cause no sh_start.
- R8: While brk_active is 1 and brk_clr_en is 1, the two-step clear works, and a flag cleared this way stays 0 after brk_active falls.
- R9: A first step taken before a protected break, followed by a data_rd after the break, clears the flag.
- R10: irq_err equals ovf AND err_ie, and irq_rx equals rx_full AND rx_ie.
- R11: While stop_mode is 1, no flag, rx_data or stored first step changes, and sh_start stays 0. Normal operation continues once stop_mode falls.
- R12: A reset asserted during stop_mode returns every output to the R1 state and marks the shifter idle, so the next write starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_rd | input | 1 | CPU status register read strobe |
| data_rd | input | 1 | CPU data register read strobe |
| data_wr | input | 1 | CPU data register write strobe |
| wr_byte | input | DW | Byte written with data_wr |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| brk_active | input | 1 | Debug break state |
| brk_clr_en | input | 1 | Allow flag clearing during break |
| stop_mode | input | 1 | Stop mode, block frozen |
| sh_done | input | 1 | Shifter transfer-complete pulse |
| sh_rx_byte | input | DW | Byte received by the shifter |
| tx_empty | output | 1 | Transmit buffer empty flag |
| rx_full | output | 1 | Receive full flag |
| ovf | output | 1 | Overflow flag |
| rx_data | output | DW | Received byte shown to the CPU |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |
| sh_start | output | 1 | Shifter start strobe |
| sh_tx_byte | output | DW | Byte handed to the shifter |

## Verification
Every flag, rx_data, sh_start and sh_tx_byte is a register, so each changes on the first clock edge after the strobe that causes it. The interrupt requests follow their flags with no extra delay. The bench drives inputs on the falling edge and samples all outputs on the next falling edge, exactly one rising edge later, and compares them with a cycle model built from the requirements. A check that a strobe had no effect, such as a protected read or a write during stop, is made one edge after the strobe and again after break or stop is released.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
   localparam int unsigned N_TWO_STEP = 2;
   localparam int unsigned IDX_RXF    = 0;
   localparam int unsigned IDX_OVF    = 1;
endpackage

// File: rtl/spi_flag_ctrl_clr2.sv
// Two-step clear sequencer: remembers a status read that saw the flag set,
// then fires a clear on the next permitted data read.
module spi_flag_ctrl_clr2 (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic stat_rd,
   input  logic data_rd,
   input  logic flag,
   output logic clr
);
   logic armed;

   assign clr = active && data_rd && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (active) begin
         if (clr)
            armed <= 1'b0;
         else if (stat_rd && flag)
            armed <= 1'b1;
      end
   end
endmodule

// File: rtl/spi_flag_ctrl_tx.sv
// Transmit side: one holding byte plus shifter-busy tracking.
module spi_flag_ctrl_tx #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          permit,
   input  logic          data_wr,
   input  logic [DW-1:0] wr_byte,
   input  logic          sh_done,
   output logic          tx_empty,
   output logic          sh_start,
   output logic [DW-1:0] sh_tx_byte
);
   logic          busy;
   logic [DW-1:0] hold_q;
   logic          wr_ok;
   logic          free;

   assign wr_ok = permit && data_wr;
   assign free  = !busy || sh_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         tx_empty   <= 1'b1;
         sh_start   <= 1'b0;
         sh_tx_byte <= '0;
         hold_q     <= '0;
      end else begin
         sh_start <= 1'b0;
         if (run) begin
            if (free && wr_ok) begin
               sh_start   <= 1'b1;
               sh_tx_byte <= wr_byte;
               busy       <= 1'b1;
               tx_empty   <= 1'b1;
            end else if (free && !tx_empty) begin
               sh_start   <= 1'b1;
               sh_tx_byte <= hold_q;
               busy       <= 1'b1;
               tx_empty   <= 1'b1;
            end else begin
               if (sh_done)
                  busy <= 1'b0;
               if (wr_ok) begin
                  hold_q   <= wr_byte;
                  tx_empty <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
   import spi_flag_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stat_rd,
   input  logic          data_rd,
   input  logic          data_wr,
   input  logic [DW-1:0] wr_byte,
   input  logic          rx_ie,
   input  logic          err_ie,
   input  logic          brk_active,
   input  logic          brk_clr_en,
   input  logic          stop_mode,
   input  logic          sh_done,
   input  logic [DW-1:0] sh_rx_byte,
   output logic          tx_empty,
   output logic          rx_full,
   output logic          ovf,
   output logic [DW-1:0] rx_data,
   output logic          irq_rx,
   output logic          irq_err,
   output logic          sh_start,
   output logic [DW-1:0] sh_tx_byte
);
   generate
      if (DW < 1) begin : g_bad_width
         $error("spi_flag_ctrl: DW must be at least 1");
      end
   endgenerate

   logic                  run;
   logic                  permit;
   logic [N_TWO_STEP-1:0] flag_vec;
   logic [N_TWO_STEP-1:0] clr_vec;
   logic                  rx_overrun;

   assign run    = !stop_mode;
   assign permit = run && !(brk_active && !brk_clr_en);

   assign flag_vec[IDX_RXF] = rx_full;
   assign flag_vec[IDX_OVF] = ovf;

   generate
      for (genvar i = 0; i < N_TWO_STEP; i++) begin : g_seq
         spi_flag_ctrl_clr2 u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (permit),
            .stat_rd (stat_rd),
            .data_rd (data_rd),
            .flag    (flag_vec[i]),
            .clr     (clr_vec[i])
         );
      end
   endgenerate

   assign rx_overrun = sh_done && rx_full && !clr_vec[IDX_RXF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_full <= 1'b0;
         ovf     <= 1'b0;
         rx_data <= '0;
      end else if (run) begin
         if (rx_overrun)
            ovf <= 1'b1;
         else if (clr_vec[IDX_OVF])
            ovf <= 1'b0;

         if (sh_done && !rx_overrun) begin
            rx_full <= 1'b1;
            rx_data <= sh_rx_byte;
         end else if (clr_vec[IDX_RXF]) begin
            rx_full <= 1'b0;
         end
      end
   end

   spi_flag_ctrl_tx #(.DW(DW)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .permit     (permit),
      .data_wr    (data_wr),
      .wr_byte    (wr_byte),
      .sh_done    (sh_done),
      .tx_empty   (tx_empty),
      .sh_start   (sh_start),
      .sh_tx_byte (sh_tx_byte)
   );

   assign irq_rx  = rx_full && rx_ie;
   assign irq_err = ovf && err_ie;
endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk #(
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          data_rd,
   input logic          data_wr,
   input logic          sh_done,
   input logic          brk_active,
   input logic          brk_clr_en,
   input logic          stop_mode,
   input logic          tx_empty,
   input logic          rx_full,
   input logic          ovf,
   input logic [DW-1:0] rx_data,
   input logic          sh_start
);
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (tx_empty && !rx_full && !ovf && !sh_start));

   assert_ovf_keeps_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_done && rx_full && !data_rd && !stop_mode) |=> (ovf && $stable(rx_data)));

   assert_rxf_clear_by_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |-> $past(data_rd));

   assert_start_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sh_start |-> $past(data_wr || sh_done));

   assert_break_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_active && !brk_clr_en && !sh_done && !stop_mode)
      |=> ($stable(tx_empty) && $stable(rx_full) && $stable(ovf)));

   assert_stop_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_mode |=> ($stable(tx_empty) && $stable(rx_full) && $stable(ovf)
                     && $stable(rx_data) && !sh_start));
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .data_rd    (data_rd),
   .data_wr    (data_wr),
   .sh_done    (sh_done),
   .brk_active (brk_active),
   .brk_clr_en (brk_clr_en),
   .stop_mode  (stop_mode),
   .tx_empty   (tx_empty),
   .rx_full    (rx_full),
   .ovf        (ovf),
   .rx_data    (rx_data),
   .sh_start   (sh_start)
);

// File: tb/spi_flag_ctrl_bench.sv
module spi_flag_ctrl_bench;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic stat_rd = 0, data_rd = 0, data_wr = 0, rx_ie = 0, err_ie = 0;
   logic brk_active = 0, brk_clr_en = 0, stop_mode = 0, sh_done = 0;
   logic [DW-1:0] wr_byte = '0, sh_rx_byte = '0;
   logic tx_empty, rx_full, ovf, irq_rx, irq_err, sh_start;
   logic [DW-1:0] rx_data, sh_tx_byte;

   spi_flag_ctrl #(.DW(DW)) u_spi_flag_ctrl (
      .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
      .data_wr(data_wr), .wr_byte(wr_byte), .rx_ie(rx_ie), .err_ie(err_ie),
      .brk_active(brk_active), .brk_clr_en(brk_clr_en), .stop_mode(stop_mode),
      .sh_done(sh_done), .sh_rx_byte(sh_rx_byte), .tx_empty(tx_empty),
      .rx_full(rx_full), .ovf(ovf), .rx_data(rx_data), .irq_rx(irq_rx),
      .irq_err(irq_err), .sh_start(sh_start), .sh_tx_byte(sh_tx_byte));

   int checks = 0;
   int errors = 0;

   // reference model state
   logic m_txe, m_rxf, m_ovf, m_arm_r, m_arm_o, m_busy, m_start;
   logic [DW-1:0] m_hold, m_rxd, m_txb;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic m_reset();
      m_txe = 1; m_rxf = 0; m_ovf = 0; m_arm_r = 0; m_arm_o = 0;
      m_busy = 0; m_start = 0; m_hold = '0; m_rxd = '0; m_txb = '0;
   endtask

   task automatic m_step();
      logic act, clr_r, clr_o, hit, wr_ok, free;
      if (!rst_n) begin
         m_reset();
         return;
      end
      m_start = 0;
      if (stop_mode) return;
      act   = !(brk_active && !brk_clr_en);
      clr_r = act && data_rd && m_arm_r;
      clr_o = act && data_rd && m_arm_o;
      hit   = sh_done && m_rxf && !clr_r;
      wr_ok = act && data_wr;
      free  = !m_busy || sh_done;
      if (act) begin
         if (clr_r) m_arm_r = 0; else if (stat_rd && m_rxf) m_arm_r = 1;
         if (clr_o) m_arm_o = 0; else if (stat_rd && m_ovf) m_arm_o = 1;
      end
      if (hit) m_ovf = 1; else if (clr_o) m_ovf = 0;
      if (sh_done && !hit) begin m_rxf = 1; m_rxd = sh_rx_byte; end
      else if (clr_r) m_rxf = 0;
      if (free && wr_ok) begin
         m_start = 1; m_txb = wr_byte; m_busy = 1; m_txe = 1;
      end else if (free && !m_txe) begin
         m_start = 1; m_txb = m_hold; m_busy = 1; m_txe = 1;
      end else begin
         if (sh_done) m_busy = 0;
         if (wr_ok) begin m_hold = wr_byte; m_txe = 0; end
      end
   endtask

   task automatic compare_all();
      chk("R6 tx_empty", tx_empty, m_txe);
      chk("R6 sh_start", sh_start, m_start);
      if (m_start) chk("R6 sh_tx_byte", sh_tx_byte, m_txb);
      chk("R2 rx_full", rx_full, m_rxf);
      chk("R2 rx_data", rx_data, m_rxd);
      chk("R3 ovf", ovf, m_ovf);
      chk("R10 irq_rx", irq_rx, m_rxf && rx_ie);
      chk("R10 irq_err", irq_err, m_ovf && err_ie);
   endtask

   task automatic step();
      @(posedge clk);
      m_step();
      @(negedge clk);
      compare_all();
      stat_rd = 0; data_rd = 0; data_wr = 0; sh_done = 0;
   endtask

   task automatic rx_byte(logic [DW-1:0] b);
      sh_done = 1; sh_rx_byte = b; step();
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL all watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      step();
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 rx_full", rx_full, 0);
      chk("R1 ovf", ovf, 0);
      chk("R1 sh_start", sh_start, 0);
      chk("R1 rx_data", rx_data, 0);

      rx_byte(8'hA5);
      chk("R2 rx_full set", rx_full, 1);
      chk("R2 rx_data", rx_data, 8'hA5);
      rx_byte(8'h3C);
      chk("R3 ovf set", ovf, 1);
      chk("R3 old byte kept", rx_data, 8'hA5);
      err_ie = 1; rx_ie = 1; step();
      chk("R10 irq_err", irq_err, 1);
      chk("R10 irq_rx", irq_rx, 1);
      err_ie = 0; step();
      chk("R10 irq_err masked", irq_err, 0);
      rx_ie = 0;

      data_rd = 1; step();
      chk("R4 read without first step", rx_full, 1);
      stat_rd = 1; step();
      data_rd = 1; step();
      chk("R4 rx_full cleared", rx_full, 0);
      chk("R5 ovf cleared", ovf, 0);

      wr_byte = 8'h5A; data_wr = 1; step();
      chk("R6 start pulse", sh_start, 1);
      chk("R6 start byte", sh_tx_byte, 8'h5A);
      chk("R6 tx_empty stays", tx_empty, 1);
      wr_byte = 8'hC3; data_wr = 1; step();
      chk("R6 single pulse", sh_start, 0);
      chk("R6 held clears tx_empty", tx_empty, 0);
      sh_done = 1; sh_rx_byte = 8'h01; step();
      chk("R6 held byte started", sh_tx_byte, 8'hC3);
      chk("R6 tx_empty back", tx_empty, 1);
      sh_done = 1; sh_rx_byte = 8'h02; step();
      stat_rd = 1; step(); data_rd = 1; step();
      stat_rd = 1; step(); data_rd = 1; step();

      rx_byte(8'h77);
      brk_active = 1; brk_clr_en = 0;
      stat_rd = 1; step();
      data_rd = 1; step();
      wr_byte = 8'h11; data_wr = 1; step();
      chk("R7 rx_full kept", rx_full, 1);
      chk("R7 no start", sh_start, 0);
      chk("R7 tx_empty kept", tx_empty, 1);
      brk_active = 0;
      data_rd = 1; step();
      chk("R7 no first step recorded", rx_full, 1);

      stat_rd = 1; step();
      brk_active = 1;
      data_rd = 1; step();
      chk("R9 held during break", rx_full, 1);
      brk_active = 0;
      data_rd = 1; step();
      chk("R9 cleared after break", rx_full, 0);

      rx_byte(8'h99);
      brk_active = 1; brk_clr_en = 1;
      stat_rd = 1; step();
      data_rd = 1; step();
      chk("R8 cleared in break", rx_full, 0);
      brk_active = 0; brk_clr_en = 0; step();
      chk("R8 stays cleared", rx_full, 0);

      rx_byte(8'h44);
      stop_mode = 1;
      stat_rd = 1; step();
      data_rd = 1; step();
      wr_byte = 8'h22; data_wr = 1; step();
      sh_done = 1; sh_rx_byte = 8'hEE; step();
      chk("R11 rx_full frozen", rx_full, 1);
      chk("R11 rx_data frozen", rx_data, 8'h44);
      chk("R11 no start", sh_start, 0);
      chk("R11 ovf frozen", ovf, 0);
      stop_mode = 0;
      stat_rd = 1; step();
      data_rd = 1; step();
      chk("R11 resumes", rx_full, 0);

      wr_byte = 8'h66; data_wr = 1; step();
      rx_byte(8'h12);
      stop_mode = 1; step();
      rst_n = 0; step();
      stop_mode = 0; rst_n = 1; step();
      chk("R12 tx_empty", tx_empty, 1);
      chk("R12 rx_full", rx_full, 0);
      chk("R12 rx_data", rx_data, 0);
      wr_byte = 8'h81; data_wr = 1; step();
      chk("R12 idle after reset", sh_start, 1);

      void'($urandom(32'd1234));
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         r = $urandom;
         stat_rd = r[0] & r[1];
         data_rd = r[2] & r[3];
         data_wr = r[4] & r[5] & r[6];
         sh_done = r[7] & r[8];
         wr_byte = r[23:16];
         sh_rx_byte = r[31:24];
         rx_ie = r[9];
         err_ie = r[10];
         if (i % 64 == 0) begin
            brk_active = r[11] & r[12];
            brk_clr_en = r[13];
            stop_mode  = r[14] & r[15] & r[12];
         end
         step();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule